// File: doc/BRIEF.md
# NAND Bus Timing Sequencer

This block drives a single asynchronous SDR NAND bus access at a time: a command latch, an address latch, a data write or a data read. A requester hands it one access through a valid/ready handshake. The block then produces the chip-enable, write-strobe, read-strobe, command-latch and address-latch waveforms, with every edge-to-edge interval taken from a packed 32-bit timing word. For a read, it captures the byte on the bus and reports completion with a one-cycle done pulse once chip enable has returned high.

A small configuration port loads the timing word and a ready/busy control byte. A separate poll unit uses that byte to watch the NAND busy line. Once started, it waits a programmable delay counted in units of 16 clocks, samples the line, and keeps re-sampling every 16 clocks until the device reports ready. Converting nanosecond timings into cycle counts is left to software.

Top module: `nand_bus_seq`

## Requirements
- R1: Before the strobe of any access, CE# is low with both strobes high for the setup count held in timing bits 27:22; a value of zero adds no cycle. For non-read accesses this is the whole lead-in.
- R2: After the strobe rises, CE# stays low with both strobes high for (bits 11:8 + 1) strobe-high cycles and then for the hold count in bits 31:28.
- R3: A read adds the CE#-to-RE# delay from bits 21:16 to its lead-in; zero adds nothing.
- R4: A read whose previous access was a command, address or write adds a WE#-high-to-RE#-low gap of (2 × bits 15:12 + 1) cycles to its lead-in. A read that follows a read, or that is the first access after reset, adds none.
- R5: A write, command or address strobe holds WE# low for (bits 7:4 + 1) cycles. A read strobe holds RE# low for (bits 3:0 + 1) cycles. RE# never falls during a write-type access, and WE# never falls during a read.
- R6: The read result holds the bus byte sampled on the cycle RE# rises. Non-read accesses leave it unchanged.
- R7: Request kind is coded 0 = command, 1 = address, 2 = data write, 3 = data read. CLE (kind 0) and ALE (kind 1) are high for the whole CE#-low window of the access and low otherwise. The data bus drives the request byte, with output enable high, for the whole CE#-low window of every non-read access.
- R8: The block is ready only while idle, and a request is taken in a cycle where valid and ready are both high. Done is high for exactly one cycle, directly after the CE# hold, with CE# high. The block is ready again in the cycle after done.
- R9: An access uses the timing word as it stood when the access was accepted. A configuration write in that same cycle applies from the next access on.
- R10: A poll start with the enable bit (control bit 0) set clears the poll-complete flag. The busy line is first sampled (bits 7:4) × 16 + 1 cycles after the start, and the flag rises on that sample if the line is high.
- R11: While the sampled busy line is low, the poll unit samples it again every 16 cycles until it is found high.
- R12: The ready/busy control byte resets to 0xF1. Configuration select 0 writes the timing word and select 1 writes the control byte from data bits 7:0. A poll start with the enable bit clear has no effect on the poll flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 = timing word, 1 = ready/busy control byte |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Sequencer idle and able to accept |
| req_kind | input | 2 | 0 command, 1 address, 2 data write, 3 data read |
| req_wdata | input | 8 | Byte driven on the bus for non-read accesses |
| done | output | 1 | One-cycle end-of-access pulse |
| rd_data | output | 8 | Last byte captured by a read |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_dq_out | output | 8 | Bus output byte |
| nand_dq_oe | output | 1 | Bus output enable |
| nand_dq_in | input | 8 | Bus input byte |
| nand_rb | input | 1 | Ready/busy line (high = ready), already synchronized |
| poll_start | input | 1 | Starts a ready/busy poll |
| poll_busy | output | 1 | Poll in progress |
| poll_done | output | 1 | Poll found the device ready |

## Verification
Two functions can land on the same clock edge: a configuration write of the timing word and the acceptance of a new access. The bench provokes this by raising request valid and the configuration strobe in the same cycle. It then checks that the lead-in, strobe and hold counts of that access match the old word, and that the access after it matches the new word. The gap insertion of R4 depends on the kind of the previous access, so every timing point is also swept through a fixed mix of command, read, read, write, address and read. Each measured interval is compared with a value computed arithmetically from the word's fields.

// File: rtl/nbs_pkg.sv
// Shared types for the NAND bus timing sequencer.
// Assumes a 32-bit timing word whose field order is fixed by the pin logic.
package nbs_pkg;

    localparam int TW_W  = 32;  // timing word width
    localparam int TMO_W = 4;   // poll delay field width
    localparam int LEN_W = 7;   // phase length counter width (widest field + 1)

    // Request kinds as seen on req_kind
    typedef enum logic [1:0] {
        K_CMD  = 2'd0,
        K_ADDR = 2'd1,
        K_WDAT = 2'd2,
        K_RDAT = 2'd3
    } req_kind_t;

    // Bus phases in the order they are visited; zero-length phases are skipped
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_SETUP = 3'd1,
        PH_GAP   = 3'd2,
        PH_C2R   = 3'd3,
        PH_STRB  = 3'd4,
        PH_HIGH  = 3'd5,
        PH_HOLD  = 3'd6,
        PH_DONE  = 3'd7
    } phase_t;

    // Packed access timing word, most significant field first
    typedef struct packed {
        logic [3:0] ce_hold;
        logic [5:0] ce_setup;
        logic [5:0] ce_to_re;
        logic [3:0] we_to_re;
        logic [3:0] hi_hold;
        logic [3:0] wr_wait;
        logic [3:0] rd_wait;
    } timing_t;

endpackage

// File: rtl/nbs_cfg_regs.sv
// Configuration holding registers: the access timing word and the
// ready/busy poll controls (delay field and enable bit).
// Assumes single-cycle writes; the last write in a cycle wins.
module nbs_cfg_regs
    import nbs_pkg::*;
#(
    parameter logic [TW_W-1:0] RESET_TIMING = 32'h2084_3322,
    parameter logic [7:0]      RESET_RBCTL  = 8'hF1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_sel,
    input  logic [TW_W-1:0]  cfg_wdata,
    output logic [TW_W-1:0]  timing_word,
    output logic [TMO_W-1:0] rb_tmo,
    output logic             rb_en
);

    // Timing word register
    always_ff @(posedge clk) begin
        if (!rst_n)
            timing_word <= RESET_TIMING;
        else if (cfg_we && !cfg_sel)
            timing_word <= cfg_wdata;
    end

    // Ready/busy control fields: delay in bits 7:4, enable in bit 0
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rb_tmo <= RESET_RBCTL[7:4];
            rb_en  <= RESET_RBCTL[0];
        end else if (cfg_we && cfg_sel) begin
            rb_tmo <= cfg_wdata[7:4];
            rb_en  <= cfg_wdata[0];
        end
    end

endmodule

// File: rtl/nbs_bus_fsm.sv
// One-access-at-a-time NAND bus phase sequencer. Walks SETUP, GAP, C2R,
// STRB, HIGH, HOLD and DONE, skipping phases of zero length, and decodes
// the bus pins from the current phase. Assumes the timing word is snapped
// at acceptance and that the bus input is stable around the RE# rise.
module nbs_bus_fsm
    import nbs_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [TW_W-1:0] timing_word,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [1:0]      req_kind,
    input  logic [DW-1:0]   req_wdata,
    output logic            done,
    output logic [DW-1:0]   rd_data,
    output logic            ce_n,
    output logic            we_n,
    output logic            re_n,
    output logic            cle,
    output logic            ale,
    output logic [DW-1:0]   dq_out,
    output logic            dq_oe,
    input  logic [DW-1:0]   dq_in
);

    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    phase_t            ph_q;
    logic [LEN_W-1:0]  cnt_q;
    timing_t           snap_q;
    req_kind_t         kind_q;
    logic [DW-1:0]     wdata_q;
    logic              gap_pend_q;
    logic [DW-1:0]     rd_q;

    // Number of cycles a phase lasts for a given word and access kind
    function automatic logic [LEN_W-1:0] phase_len(phase_t p, timing_t t,
                                                   logic rd, logic gp);
        case (p)
            PH_SETUP: return LEN_W'(t.ce_setup);
            PH_GAP:   return (rd && gp) ? LEN_W'({t.we_to_re, 1'b1}) : '0;
            PH_C2R:   return rd ? LEN_W'(t.ce_to_re) : '0;
            PH_STRB:  return rd ? LEN_W'(t.rd_wait) + ONE : LEN_W'(t.wr_wait) + ONE;
            PH_HIGH:  return LEN_W'(t.hi_hold) + ONE;
            PH_HOLD:  return LEN_W'(t.ce_hold);
            PH_DONE:  return ONE;
            default:  return '0;
        endcase
    endfunction

    // First phase after p with a non-zero length; DONE leads back to IDLE
    function automatic phase_t phase_after(phase_t p, timing_t t,
                                           logic rd, logic gp);
        phase_t n;
        n = (p == PH_DONE) ? PH_IDLE : PH_DONE;
        for (int i = 6; i >= 1; i--) begin
            if (i > int'(p) && phase_len(phase_t'(i), t, rd, gp) != '0)
                n = phase_t'(i);
        end
        return n;
    endfunction

    logic             acc_fire;
    logic             req_rd;
    logic             cur_rd;
    logic             bus_active;
    phase_t           first_ph;
    phase_t           next_ph;
    logic [LEN_W-1:0] first_len;
    logic [LEN_W-1:0] next_len;

    // Acceptance and next-phase selection
    always_comb begin
        acc_fire  = req_valid && (ph_q == PH_IDLE);
        req_rd    = (req_kind_t'(req_kind) == K_RDAT);
        cur_rd    = (kind_q == K_RDAT);
        first_ph  = phase_after(PH_IDLE, timing_t'(timing_word), req_rd, gap_pend_q);
        first_len = phase_len(first_ph, timing_t'(timing_word), req_rd, gap_pend_q);
        next_ph   = phase_after(ph_q, snap_q, cur_rd, gap_pend_q);
        next_len  = phase_len(next_ph, snap_q, cur_rd, gap_pend_q);
    end

    // Phase register and per-phase down counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q  <= PH_IDLE;
            cnt_q <= '0;
        end else if (acc_fire) begin
            ph_q  <= first_ph;
            cnt_q <= first_len - ONE;
        end else if (ph_q != PH_IDLE) begin
            if (cnt_q == '0) begin
                ph_q  <= next_ph;
                cnt_q <= (next_len == '0) ? '0 : next_len - ONE;
            end else begin
                cnt_q <= cnt_q - ONE;
            end
        end
    end

    // Snapshot of timing word, kind and write byte at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_q  <= '0;
            kind_q  <= K_CMD;
            wdata_q <= '0;
        end else if (acc_fire) begin
            snap_q  <= timing_t'(timing_word);
            kind_q  <= req_kind_t'(req_kind);
            wdata_q <= req_wdata;
        end
    end

    // Read byte capture on the edge that ends the RE# low phase
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_q <= '0;
        else if (ph_q == PH_STRB && cur_rd && cnt_q == '0)
            rd_q <= dq_in;
    end

    // Remembers whether the last finished access raised WE#
    always_ff @(posedge clk) begin
        if (!rst_n)
            gap_pend_q <= 1'b0;
        else if (ph_q == PH_DONE)
            gap_pend_q <= !cur_rd;
    end

    // Pin decode from the phase register
    always_comb begin
        bus_active = (ph_q != PH_IDLE) && (ph_q != PH_DONE);
        ce_n       = !bus_active;
        we_n       = !(ph_q == PH_STRB && !cur_rd);
        re_n       = !(ph_q == PH_STRB && cur_rd);
        cle        = bus_active && (kind_q == K_CMD);
        ale        = bus_active && (kind_q == K_ADDR);
        dq_oe      = bus_active && !cur_rd;
        dq_out     = wdata_q;
        done       = (ph_q == PH_DONE);
        req_ready  = (ph_q == PH_IDLE);
        rd_data    = rd_q;
    end

    // A strobe only falls while chip enable is already low
    p_strobe_in_ce_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(we_n) || $fell(re_n)) |-> (!ce_n && $past(!ce_n) || $past(ce_n)));

    // The byte reported after RE# rises is the one on the bus at that edge
    p_read_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(re_n) |-> (rd_data == $past(dq_in)));

    // Latch enables and data hold steady while CE# stays low
    p_pins_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && $past(!ce_n)) |-> ($stable(cle) && $stable(ale) && $stable(dq_out)));

    // Done comes straight after the CE# low window and lasts one cycle
    p_done_after_ce_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ce_n && $past(!ce_n)));
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready));

    // Word in use cannot move during an access
    p_snap_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> $stable(snap_q));

endmodule

// File: rtl/nbs_rb_poll.sv
// Ready/busy poll unit. On an enabled start it waits delay x STEP cycles,
// samples the busy line and, while the line reads low, samples again every
// STEP cycles. Assumes the busy line is synchronized outside this block.
module nbs_rb_poll
    import nbs_pkg::*;
#(
    parameter int STEP = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TMO_W-1:0] rb_tmo,
    input  logic             rb_en,
    input  logic             poll_start,
    input  logic             rb_line,
    output logic             poll_busy,
    output logic             poll_done
);

    localparam int CNT_W = TMO_W + $clog2(STEP);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(STEP - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;
    logic             done_q;
    logic             go;

    // Enabled start request
    always_comb go = poll_start && rb_en;

    // Wait counter, in-progress flag and complete flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else if (go) begin
            cnt_q  <= CNT_W'(rb_tmo) * CNT_W'(STEP);
            busy_q <= 1'b1;
            done_q <= 1'b0;
        end else if (busy_q) begin
            if (cnt_q != '0) begin
                cnt_q <= cnt_q - CNT_W'(1);
            end else if (rb_line) begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
            end else begin
                cnt_q <= RELOAD;
            end
        end
    end

    assign poll_busy = busy_q;
    assign poll_done = done_q;

    // An enabled start clears the result and marks the unit busy
    p_start_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_start && rb_en) |=> (poll_busy && !poll_done));

    // Completion never coexists with a running poll
    p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        poll_done |-> !poll_busy);

    // A disabled start leaves an idle unit untouched
    p_disabled_start_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_start && !rb_en && !poll_busy) |=> ($stable(poll_done) && !poll_busy));

endmodule

// File: rtl/nand_bus_seq.sv
// Top of the NAND bus timing sequencer: configuration registers, the bus
// phase sequencer and the ready/busy poll unit. Assumes one requester and
// a busy line already brought into the clock domain.
module nand_bus_seq
    import nbs_pkg::*;
#(
    parameter int               DW           = 8,
    parameter int               POLL_STEP    = 16,
    parameter logic [TW_W-1:0]  RESET_TIMING = 32'h2084_3322
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic            cfg_sel,
    input  logic [TW_W-1:0] cfg_wdata,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [1:0]      req_kind,
    input  logic [DW-1:0]   req_wdata,
    output logic            done,
    output logic [DW-1:0]   rd_data,
    output logic            nand_ce_n,
    output logic            nand_we_n,
    output logic            nand_re_n,
    output logic            nand_cle,
    output logic            nand_ale,
    output logic [DW-1:0]   nand_dq_out,
    output logic            nand_dq_oe,
    input  logic [DW-1:0]   nand_dq_in,
    input  logic            nand_rb,
    input  logic            poll_start,
    output logic            poll_busy,
    output logic            poll_done
);

    logic [TW_W-1:0]  timing_word;
    logic [TMO_W-1:0] rb_tmo;
    logic             rb_en;

    nbs_cfg_regs #(
        .RESET_TIMING (RESET_TIMING),
        .RESET_RBCTL  (8'hF1)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_sel     (cfg_sel),
        .cfg_wdata   (cfg_wdata),
        .timing_word (timing_word),
        .rb_tmo      (rb_tmo),
        .rb_en       (rb_en)
    );

    nbs_bus_fsm #(
        .DW (DW)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .timing_word (timing_word),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_kind    (req_kind),
        .req_wdata   (req_wdata),
        .done        (done),
        .rd_data     (rd_data),
        .ce_n        (nand_ce_n),
        .we_n        (nand_we_n),
        .re_n        (nand_re_n),
        .cle         (nand_cle),
        .ale         (nand_ale),
        .dq_out      (nand_dq_out),
        .dq_oe       (nand_dq_oe),
        .dq_in       (nand_dq_in)
    );

    nbs_rb_poll #(
        .STEP (POLL_STEP)
    ) u_poll (
        .clk        (clk),
        .rst_n      (rst_n),
        .rb_tmo     (rb_tmo),
        .rb_en      (rb_en),
        .poll_start (poll_start),
        .rb_line    (nand_rb),
        .poll_busy  (poll_busy),
        .poll_done  (poll_done)
    );

endmodule

// File: tb/nand_bus_seq_test.sv
// Sweep bench for the NAND bus timing sequencer: measures every bus
// interval at the pins and compares it with values computed from the word.
module nand_bus_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_kind = 2'd0;
    logic [7:0]  req_wdata = '0;
    logic        done;
    logic [7:0]  rd_data;
    logic        nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale;
    logic [7:0]  nand_dq_out;
    logic        nand_dq_oe;
    logic [7:0]  nand_dq_in = '0;
    logic        nand_rb = 1'b1;
    logic        poll_start = 1'b0;
    logic        poll_busy, poll_done;

    int total = 0;
    int bad = 0;

    // 125 MHz
    always #4 clk = ~clk;

    nand_bus_seq uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_wdata(req_wdata), .done(done),
        .rd_data(rd_data), .nand_ce_n(nand_ce_n), .nand_we_n(nand_we_n),
        .nand_re_n(nand_re_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe),
        .nand_dq_in(nand_dq_in), .nand_rb(nand_rb), .poll_start(poll_start),
        .poll_busy(poll_busy), .poll_done(poll_done)
    );

    // Pin monitor state, cleared by the access task
    int n_pre, n_strb, n_post, n_done, bad_sig, bad_rdy;
    int cur_kind = 0;
    logic [7:0] cur_wdata = '0;
    bit gap_model = 1'b0;
    logic [7:0] last_rd = '0;

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Classifies each CE#-low cycle and checks pin consistency
    always @(negedge clk) begin
        if (rst_n) begin
            if (!nand_ce_n) begin
                if (!nand_we_n || !nand_re_n) n_strb = n_strb + 1;
                else if (n_strb == 0)         n_pre = n_pre + 1;
                else                          n_post = n_post + 1;
                if (nand_cle != (cur_kind == 0) || nand_ale != (cur_kind == 1) ||
                    nand_dq_oe != (cur_kind != 3)) bad_sig = bad_sig + 1;
                if (cur_kind == 3 && !nand_we_n) bad_sig = bad_sig + 1;
                if (cur_kind != 3 && !nand_re_n) bad_sig = bad_sig + 1;
                if (cur_kind != 3 && nand_dq_out != cur_wdata) bad_sig = bad_sig + 1;
                if (req_ready) bad_rdy = bad_rdy + 1;
            end else if (nand_cle || nand_ale || nand_dq_oe) begin
                bad_sig = bad_sig + 1;
            end
            if (done) begin
                n_done = n_done + 1;
                if (!nand_ce_n) bad_rdy = bad_rdy + 1;
            end
        end
    end

    function automatic logic [31:0] mk(int ceh, int ces, int c2r, int w2r,
                                       int wh, int wst, int rlt);
        return {4'(ceh), 6'(ces), 6'(c2r), 4'(w2r), 4'(wh), 4'(wst), 4'(rlt)};
    endfunction

    task automatic cfg_write(input bit sel, input logic [31:0] d);
        @(negedge clk); #2;
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk); #2;
        cfg_we = 1'b0;
    endtask

    // One access; w is the word the access must use
    task automatic do_access(input int kind, input logic [7:0] wd,
                             input logic [7:0] din, input logic [31:0] w,
                             input bit cfg_now, input logic [31:0] cfg_word);
        int e_pre, e_strb, e_post, e_rd;
        bit rd;
        string ptag;
        rd = (kind == 3);
        e_pre = int'(w[27:22]);
        if (rd) e_pre += (gap_model ? 2 * int'(w[15:12]) + 1 : 0) + int'(w[21:16]);
        e_strb = rd ? int'(w[3:0]) + 1 : int'(w[7:4]) + 1;
        e_post = int'(w[11:8]) + 1 + int'(w[31:28]);
        ptag = rd ? (gap_model ? "R4 lead-in" : "R3 lead-in") : "R1 lead-in";
        e_rd = rd ? int'(din) : int'(last_rd);
        @(negedge clk); #2;
        n_pre = 0; n_strb = 0; n_post = 0; n_done = 0; bad_sig = 0; bad_rdy = 0;
        cur_kind = kind; cur_wdata = wd; nand_dq_in = din;
        req_valid = 1'b1; req_kind = 2'(kind); req_wdata = wd;
        if (cfg_now) begin cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = cfg_word; end
        @(negedge clk); #2;
        req_valid = 1'b0; cfg_we = 1'b0;
        while (n_done == 0) begin @(negedge clk); #2; end
        @(negedge clk); #2;
        chk(ptag, n_pre, e_pre);
        chk("R5 strobe width", n_strb, e_strb);
        chk("R2 strobe-high plus hold", n_post, e_post);
        chk("R7 latch enables and bus drive", bad_sig, 0);
        chk("R8 done count", n_done, 1);
        chk("R8 ready and CE# at done", bad_rdy, 0);
        chk("R8 ready after done", int'(req_ready), 1);
        chk(rd ? "R6 read capture" : "R6 read result kept", int'(rd_data), e_rd);
        gap_model = !rd;
        if (rd) last_rd = din;
    endtask

    // Poll run; raise_at = 0 means line already high
    task automatic run_poll(input int raise_at, input int exp_k, input string tag);
        int k;
        nand_rb = (raise_at == 0);
        @(negedge clk); #2;
        poll_start = 1'b1;
        @(negedge clk); #2;
        poll_start = 1'b0;
        k = 0;
        while (!poll_done && k < 2000) begin
            @(negedge clk); #2;
            k++;
            if (k == raise_at) nand_rb = 1'b1;
        end
        chk(tag, k, exp_k);
    endtask

    initial begin
        int ces_l[3] = '{0, 1, 3};
        int c2r_l[2] = '{0, 2};
        int w2r_l[3] = '{0, 1, 3};
        int wh_l[2]  = '{0, 2};
        int wst_l[2] = '{0, 3};
        int rlt_l[2] = '{0, 5};
        int ceh_l[2] = '{0, 2};
        logic [31:0] w, wa, wb;
        logic [7:0] seed;

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R8 reset CE# high", int'(nand_ce_n), 1);
        chk("R8 reset strobes high", int'(nand_we_n & nand_re_n), 1);
        chk("R8 reset ready", int'(req_ready), 1);
        chk("R8 reset done low", int'(done), 0);
        chk("R10 reset poll flags", int'(poll_done | poll_busy), 0);
        #2 rst_n = 1'b1;

        // R12: default control byte gives 15 x 16 delay with polling enabled
        run_poll(0, 15 * 16 + 1, "R12 default control delay");

        seed = 8'h11;
        for (int a = 0; a < 3; a++)
        for (int b = 0; b < 2; b++)
        for (int c = 0; c < 3; c++)
        for (int d = 0; d < 2; d++)
        for (int e = 0; e < 2; e++)
        for (int f = 0; f < 2; f++)
        for (int g = 0; g < 2; g++) begin
            w = mk(ceh_l[g], ces_l[a], c2r_l[b], w2r_l[c], wh_l[d], wst_l[e], rlt_l[f]);
            cfg_write(1'b0, w);
            do_access(0, seed ^ 8'h0F, seed, w, 1'b0, '0);
            do_access(3, 8'h00, seed + 8'd1, w, 1'b0, '0);
            do_access(3, 8'h00, seed + 8'd2, w, 1'b0, '0);
            do_access(2, seed ^ 8'hA5, 8'hEE, w, 1'b0, '0);
            do_access(1, seed ^ 8'h3C, 8'hDD, w, 1'b0, '0);
            do_access(3, 8'h00, seed + 8'd3, w, 1'b0, '0);
            seed = seed + 8'd7;
        end

        // R9: word written in the accepting cycle applies to the next access
        wa = mk(1, 2, 1, 1, 0, 1, 2);
        wb = mk(3, 5, 4, 2, 3, 2, 6);
        cfg_write(1'b0, wa);
        do_access(2, 8'h42, 8'h00, wa, 1'b0, '0);
        do_access(3, 8'h00, 8'h9C, wa, 1'b1, wb);   // R9: old word in use
        do_access(3, 8'h00, 8'h63, wb, 1'b0, '0);   // R9: new word in use

        // R10: delay of 2 x 16 and of zero
        cfg_write(1'b1, 32'h0000_0021);
        run_poll(0, 2 * 16 + 1, "R10 poll delay");
        cfg_write(1'b1, 32'h0000_0001);
        run_poll(0, 1, "R10 poll zero delay");

        // R11: busy line low at the first sample, then at two samples
        cfg_write(1'b1, 32'h0000_0011);
        run_poll(16 + 5, 16 + 17, "R11 one resample");
        run_poll(16 + 20, 16 + 33, "R11 two resamples");

        // R12: disabled start leaves flags unchanged
        cfg_write(1'b1, 32'h0000_00F0);
        nand_rb = 1'b0;
        @(negedge clk); #2;
        poll_start = 1'b1;
        @(negedge clk); #2;
        poll_start = 1'b0;
        repeat (3) begin @(negedge clk); #2; end
        chk("R12 disabled start keeps done", int'(poll_done), 1);
        chk("R12 disabled start stays idle", int'(poll_busy), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule